// File: doc/BRIEF.md
# Two-Register I2C Power Channel Controller

This block is an I2C target that holds the settings for two power channels in two 8-bit control registers. No register-address byte is sent. Bit 7 of every data byte the master writes routes that byte to one of the two registers. A read returns the registers one after the other, MSB first. In each returned byte the stored control bits are merged with live fault flags that are read-only. From the stored bits the block drives an enable and a decoded mode field for each channel, and a channel's mode field is forced to zero while its enable bit is clear.

The device address has seven bits, and its least significant bit comes from a strap input. A power-good input acts as a functional reset. While it is low, both registers are held at zero and the bus is ignored. SCL and SDA arrive already synchronised to `clk`. The block pulls SDA low through an open-drain enable and never drives it high.

Top module: `dual_ctrl_i2c_target`

## Requirements
- R1: The target acknowledges (pulls SDA low during the ninth clock) only the address 0001000 when `addr_sel` is 0, and only 0001001 when `addr_sel` is 1. Any other address gets no acknowledge and is ignored until the next START.
- R2: The eighth address bit selects the direction, with 0 for a write and 1 for a read. Every data byte written after an acknowledged write address is acknowledged.
- R3: A written byte with bit 7 = 0 stores its bits 6..1 into register 1. A written byte with bit 7 = 1 stores its bits 6..2 into register 2. The other register is left unchanged.
- R4: Register 1 bit 0 reads `ovl1`. Register 2 bit 1 reads `ot_flag` and bit 0 reads `ovl2`. These read-only bits show the live inputs and are not affected by any write.
- R5: A read byte goes out MSB first. The byte for register 1 is {0, stored bits 6..1, ovl1} and the byte for register 2 is {1, stored bits 6..2, ot_flag, ovl2}. `sda_oe` changes only while SCL is low.
- R6: The first byte of a read is register 1. Each byte the master acknowledges is followed by the other register, so the order alternates. A NACK ends the read and the target releases SDA.
- R7: Every START, repeated or not, restarts the read order at register 1.
- R8: A STOP or a repeated START in the middle of a byte abandons that byte without changing either register, and the target then waits for an address.
- R9: While `pwr_ok` is low, both registers read as zero, all channel outputs are zero and no address is acknowledged. After `rst_n` is released all outputs are zero.
- R10: `ch1_en` is register 1 bit 1. `ch1_mode` is register 1 bits 6..2 when `ch1_en` is 1, else 0. `ch2_en` is register 2 bit 2. `ch2_mode` is register 2 bits 6..3 when `ch2_en` is 1, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_ok | input | 1 | Power good; low clears registers and idles the bus logic |
| addr_sel | input | 1 | Strap that sets the least significant address bit |
| scl | input | 1 | Synchronised bus clock |
| sda | input | 1 | Synchronised bus data (wired-AND level) |
| ovl1 | input | 1 | Live overload flag, channel 1 |
| ovl2 | input | 1 | Live overload flag, channel 2 |
| ot_flag | input | 1 | Live over-temperature flag |
| sda_oe | output | 1 | 1 pulls SDA low |
| ch1_en | output | 1 | Channel 1 enable |
| ch1_mode | output | 5 | Channel 1 mode bits, zero when disabled |
| ch2_en | output | 1 | Channel 2 enable |
| ch2_mode | output | 4 | Channel 2 mode bits, zero when disabled |

## Verification
The address decoder is tried with all 128 addresses under both strap levels, so a wrong fixed bit or a strap wired to the wrong position gets an acknowledge in the wrong place. All 256 data byte values are written one after another with a changing pattern of fault flags, and each is read back. This separates the routing by bit 7, the position of every stored bit, the enable gating of the mode outputs and a stored read-only bit from a live one. Three-byte reads, repeated STARTs and STOPs inside a byte tell the alternating read order apart from a fixed one, and show that abandoned bytes leave no trace. Dropping power-good with the registers non-zero shows the clear and the silenced decoder.

// File: rtl/dual_ctrl_i2c_target.sv
module dual_ctrl_i2c_target #(
  parameter logic [5:0] DEV_ADDR_HI = 6'b000100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_ok,
  input  logic       addr_sel,
  input  logic       scl,
  input  logic       sda,
  input  logic       ovl1,
  input  logic       ovl2,
  input  logic       ot_flag,
  output logic       sda_oe,
  output logic       ch1_en,
  output logic [4:0] ch1_mode,
  output logic       ch2_en,
  output logic [3:0] ch2_mode
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ADDR_ACK, S_WR, S_WR_ACK, S_RD, S_RD_ACK} st_t;

  st_t        st;
  logic       scl_q, sda_q, rw, rd_sel, m_ack;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic [6:1] r1;
  logic [6:2] r2;

  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;
  wire addr_hit = (sh[7:1] == {DEV_ADDR_HI, addr_sel});
  wire [7:0] rd1 = {1'b0, r1, ovl1};
  wire [7:0] rd2 = {1'b1, r2, ot_flag, ovl2};
  wire [7:0] rd_next = rd_sel ? rd2 : rd1;

  assign ch1_en   = r1[1];
  assign ch1_mode = r1[1] ? r1[6:2] : 5'd0;
  assign ch2_en   = r2[2];
  assign ch2_mode = r2[2] ? r2[6:3] : 4'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; scl_q <= 1'b1; sda_q <= 1'b1; sda_oe <= 1'b0;
      cnt <= '0; sh <= '0; rw <= 1'b0; rd_sel <= 1'b0; m_ack <= 1'b0;
      r1 <= '0; r2 <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (!pwr_ok) begin
        st <= S_IDLE; sda_oe <= 1'b0; cnt <= '0; rd_sel <= 1'b0;
        r1 <= '0; r2 <= '0;
      end else if (start_c) begin
        st <= S_ADDR; sda_oe <= 1'b0; cnt <= '0; rd_sel <= 1'b0;
      end else if (stop_c) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WR:
            if (scl_rise) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_WR) begin
                if (sh[7]) r2 <= sh[6:2];
                else       r1 <= sh[6:1];
                sda_oe <= 1'b1;
                st     <= S_WR_ACK;
              end else if (addr_hit) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                st     <= S_ADDR_ACK;
              end else begin
                st <= S_IDLE;
              end
            end
          S_ADDR_ACK:
            if (scl_fall) begin
              if (rw) begin
                sh <= rd1; sda_oe <= ~rd1[7]; cnt <= 4'd1; rd_sel <= 1'b1; st <= S_RD;
              end else begin
                sda_oe <= 1'b0; cnt <= '0; st <= S_WR;
              end
            end
          S_WR_ACK:
            if (scl_fall) begin
              sda_oe <= 1'b0; cnt <= '0; st <= S_WR;
            end
          S_RD:
            if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_oe <= 1'b0; st <= S_RD_ACK;
              end else begin
                sda_oe <= ~sh[6]; sh <= {sh[6:0], 1'b0}; cnt <= cnt + 4'd1;
              end
            end
          S_RD_ACK:
            if (scl_rise) m_ack <= ~sda;
            else if (scl_fall) begin
              if (m_ack) begin
                sh <= rd_next; sda_oe <= ~rd_next[7]; rd_sel <= ~rd_sel;
                cnt <= 4'd1; st <= S_RD;
              end else begin
                st <= S_IDLE;
              end
            end
          default: ;
        endcase
      end
    end
  end

  a_r1_ack_own_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR_ACK) |-> (sh[7:1] == {DEV_ADDR_HI, addr_sel}));
  a_r5_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && $past(scl) && $past(pwr_ok)) |-> $stable(sda_oe));
  a_r6_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  a_r8_regs_change_on_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({r1, r2}) |-> ($past(!pwr_ok) || $past(st == S_WR && scl_fall && cnt == 4'd8)));
  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_ok && stop_c) |=> (st == S_IDLE));
  a_r9_power_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> (!sda_oe && !ch1_en && !ch2_en && ch1_mode == 5'd0 && ch2_mode == 4'd0));
endmodule

// File: tb/dual_ctrl_i2c_target_tb_top.sv
module dual_ctrl_i2c_target_tb_top;
  localparam int H = 4;
  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, addr_sel = 1'b0;
  logic m_scl = 1'b1, m_pull = 1'b0, ovl1 = 1'b0, ovl2 = 1'b0, ot_flag = 1'b0;
  logic sda_oe, ch1_en, ch2_en;
  logic [4:0] ch1_mode;
  logic [3:0] ch2_mode;
  wire sda_bus = ~(m_pull | sda_oe);
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [6:1] e1 = '0;
  logic [6:2] e2 = '0;

  always #4 clk = ~clk;

  dual_ctrl_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .addr_sel(addr_sel),
    .scl(m_scl), .sda(sda_bus), .ovl1(ovl1), .ovl2(ovl2), .ot_flag(ot_flag),
    .sda_oe(sda_oe), .ch1_en(ch1_en), .ch1_mode(ch1_mode),
    .ch2_en(ch2_en), .ch2_mode(ch2_mode));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_pull = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_pull = 1'b1; wt(H); m_scl = 1'b0; wt(H);
  endtask

  task automatic i2c_stop();
    m_pull = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_pull = 1'b0; wt(H);
  endtask

  task automatic wbit(input bit b);
    m_pull = ~b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] v, output bit ack);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    m_pull = 1'b0; wt(H); m_scl = 1'b1; wt(H/2); ack = ~sda_bus; wt(H/2); m_scl = 1'b0;
  endtask

  task automatic rbyte(input bit ack, output logic [7:0] v);
    m_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(H); m_scl = 1'b1; wt(H/2); v[i] = sda_bus; wt(H/2); m_scl = 1'b0;
    end
    m_pull = ack; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
  endtask

  function automatic logic [7:0] exp1();
    return {1'b0, e1, ovl1};
  endfunction
  function automatic logic [7:0] exp2();
    return {1'b1, e2, ot_flag, ovl2};
  endfunction

  task automatic chk_outputs(input string tag);
    chk(ch1_en == e1[1], tag, ch1_en, e1[1]);
    chk(ch1_mode == (e1[1] ? e1[6:2] : 5'd0), tag, ch1_mode, e1[1] ? e1[6:2] : 5'd0);
    chk(ch2_en == e2[2], tag, ch2_en, e2[2]);
    chk(ch2_mode == (e2[2] ? e2[6:3] : 4'd0), tag, ch2_mode, e2[2] ? e2[6:3] : 4'd0);
  endtask

  task automatic write_txn(input logic [7:0] v);
    bit a;
    i2c_start(); wbyte(8'h10, a); chk(a, "R2 write address ack", a, 1);
    wbyte(v, a); chk(a, "R2 data byte ack", a, 1); i2c_stop();
    if (v[7]) e2 = v[6:2]; else e1 = v[6:1];
  endtask

  initial begin
    wt(3); rst_n = 1'b1; wt(2);
    chk(!sda_oe && !ch1_en && !ch2_en && ch1_mode == 0 && ch2_mode == 0,
        "R9 reset outputs zero", {sda_oe, ch1_en, ch2_en}, 0);

    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int a = 0; a < 128; a++) begin
        bit ack;
        i2c_start(); wbyte({a[6:0], 1'b0}, ack); i2c_stop();
        chk(ack == (a == (8 + s)), "R1 address decode", ack, a == (8 + s));
      end
    end
    addr_sel = 1'b0;

    for (int v = 0; v < 256; v++) begin
      logic [7:0] b1, b2;
      bit a;
      {ovl1, ovl2, ot_flag} = {v[0] ^ v[3], v[1] ^ v[4], v[2] ^ v[5]};
      write_txn(v[7:0]);
      wt(2); chk_outputs("R10 channel outputs");
      i2c_start(); wbyte(8'h11, a); chk(a, "R2 read address ack", a, 1);
      rbyte(1'b1, b1); rbyte(1'b0, b2); i2c_stop();
      chk(b1 == exp1(), "R3 R4 R5 register 1 readback", b1, exp1());
      chk(b2 == exp2(), "R3 R4 R5 register 2 readback", b2, exp2());
    end

    begin
      logic [7:0] b1, b2, b3;
      bit a;
      write_txn(8'h2B); write_txn(8'hD6);
      ovl1 = 1'b1; ovl2 = 1'b0; ot_flag = 1'b1;
      i2c_start(); wbyte(8'h11, a);
      rbyte(1'b1, b1); rbyte(1'b1, b2); rbyte(1'b0, b3);
      wt(3); chk(!sda_oe, "R6 released after NACK", sda_oe, 0);
      i2c_stop();
      chk(b1 == exp1(), "R6 first byte register 1", b1, exp1());
      chk(b2 == exp2(), "R6 second byte register 2", b2, exp2());
      chk(b3 == exp1(), "R6 third byte register 1", b3, exp1());

      i2c_start(); wbyte(8'h11, a); rbyte(1'b1, b1);
      i2c_start(); wbyte(8'h11, a); rbyte(1'b0, b2); i2c_stop();
      chk(b2 == exp1(), "R7 repeated START restarts at register 1", b2, exp1());

      i2c_start(); wbyte(8'h10, a); wbyte(8'h7E, a); e1 = 6'h3F;
      i2c_start(); wbyte(8'h11, a); rbyte(1'b0, b1); i2c_stop();
      chk(b1 == exp1(), "R7 write then repeated START read", b1, exp1());

      i2c_start(); wbyte(8'h10, a);
      for (int i = 0; i < 4; i++) wbit(1'b0);
      i2c_stop();
      i2c_start(); wbyte(8'h10, a);
      for (int i = 0; i < 5; i++) wbit(1'b1);
      i2c_start(); wbyte(8'h11, a); rbyte(1'b1, b1); rbyte(1'b0, b2); i2c_stop();
      chk(b1 == exp1(), "R8 partial byte leaves register 1", b1, exp1());
      chk(b2 == exp2(), "R8 partial byte leaves register 2", b2, exp2());

      pwr_ok = 1'b0; wt(3);
      chk(!ch1_en && !ch2_en && ch1_mode == 0 && ch2_mode == 0, "R9 power low clears outputs",
          {ch1_en, ch2_en, ch1_mode, ch2_mode}, 0);
      i2c_start(); wbyte(8'h10, a); i2c_stop();
      chk(!a, "R9 no ack while power low", a, 0);
      pwr_ok = 1'b1; e1 = '0; e2 = '0; wt(2);
      i2c_start(); wbyte(8'h11, a); rbyte(1'b1, b1); rbyte(1'b0, b2); i2c_stop();
      chk(b1 == exp1(), "R9 register 1 cleared", b1, exp1());
      chk(b2 == exp2(), "R9 register 2 cleared", b2, exp2());
    end

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(negedge clk);
    if (!done) begin
      done = 1;
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule